// File: doc/BRIEF.md
# Single-Entry Loop Branch Predictor

This block predicts conditional branches in an instruction fetch frontend. It is built to speed up tight loops. It keeps one remembered branch address with a valid flag. When a conditional branch resolves taken with a negative offset, the block records its address. A later fetch of that same address is predicted taken. Every other branch is predicted not taken.

The fetch stage presents each decoded conditional branch address and reads back a combinational taken/not-taken prediction. The block stores each prediction in a small in-order queue until the branch resolves. The execute stage reports each resolved branch in program order: its address, whether its offset is negative (the sign bit of the immediate) and whether it was taken. The block compares the outcome with the oldest stored prediction.

On a mismatch the block raises a one-cycle mispredict pulse, which marks the single penalty cycle. It also gives the direction the fetch unit must redirect to. Target computation and the fetch address mux belong to the surrounding pipeline.

Top module: `loop_predictor`

## Requirements
- R1: After reset the remembered entry is invalid, every fetch query reads not taken, and `mispredict` is low.
- R2: A branch that resolves taken with `ex_backward`=1 becomes the remembered entry. From the next cycle on, a fetch query at that address reads taken.
- R3: A fetch query at any address other than a valid remembered one reads not taken. A forward branch is never recorded.
- R4: A branch whose stored prediction was taken and which resolves not taken invalidates the entry. The next query at that address reads not taken.
- R5: `mispredict` pulses high for exactly one cycle, the cycle after a resolve whose outcome differs from its stored prediction. In that cycle `redirect_taken` equals the actual outcome (1 = go to the target, 0 = fall through). A correct prediction raises no pulse.
- R6: A forward branch that resolves taken while predicted not taken raises a mispredict and leaves the entry unchanged.
- R7: A taken backward branch at an address different from the entry replaces it. The old address then reads not taken. A taken backward branch that matches the entry keeps it.
- R8: Up to `DEPTH` predictions can be in flight. Each resolve is paired with the oldest outstanding prediction, in fetch order.
- R9: A mispredicting resolve discards every younger stored prediction, including a fetch query presented in the same cycle.
- R10: A fetch query in the same cycle as a resolve sees the entry as it was before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_valid | input | 1 | Fetch presents a conditional branch |
| fq_addr | input | ADDR_W | Address of the fetched branch |
| fq_taken | output | 1 | Prediction for the fetched branch (combinational) |
| ex_valid | input | 1 | Execute reports a resolved branch |
| ex_addr | input | ADDR_W | Address of the resolved branch |
| ex_backward | input | 1 | Sign bit of the branch offset (1 = backward) |
| ex_taken | input | 1 | Actual direction of the resolved branch |
| mispredict | output | 1 | One-cycle pulse: stored prediction was wrong |
| redirect_taken | output | 1 | Direction to refetch when `mispredict` is high |

## Verification
A stale or wrong entry never shows up directly. It appears on `fq_taken` at the next query of the affected address, in the same cycle as that query. It appears again one cycle after that branch resolves, as an unexpected or missing `mispredict` pulse. A misaligned prediction queue does the same: a correct branch pulses, or a wrong one does not. Because of this, each scenario is arranged so that the previous state bit is the only thing that decides the next pulse. Examples are a stale taken prediction after a flush, and alternating predictions resolved in order.

// File: rtl/loop_predictor.sv
module loop_predictor #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fq_valid,
  input  logic [ADDR_W-1:0] fq_addr,
  output logic              fq_taken,
  input  logic              ex_valid,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              ex_backward,
  input  logic              ex_taken,
  output logic              mispredict,
  output logic              redirect_taken
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] ent_addr;
  logic              ent_ok;
  logic [DEPTH-1:0]  slot;
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;

  logic head_pred, wrong, pop, push, ex_hit, learn, forget;

  assign fq_taken  = fq_valid && ent_ok && (ent_addr == fq_addr);
  assign head_pred = (count != '0) && slot[rd_ptr];
  assign wrong     = ex_valid && (head_pred != ex_taken);
  assign pop       = ex_valid && (count != '0);
  assign push      = fq_valid && !wrong;
  assign ex_hit    = ent_ok && (ent_addr == ex_addr);
  assign learn     = ex_valid && ex_taken && ex_backward && !ex_hit;
  assign forget    = ex_valid && head_pred && !ex_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_ok   <= 1'b0;
      ent_addr <= '0;
    end else if (learn) begin
      ent_ok   <= 1'b1;
      ent_addr <= ex_addr;
    end else if (forget) begin
      ent_ok   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      slot   <= '0;
    end else if (wrong) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= fq_taken;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mispredict     <= 1'b0;
      redirect_taken <= 1'b0;
    end else begin
      mispredict     <= wrong;
      redirect_taken <= wrong && ex_taken;
    end
  end

  p_resolve_has_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> count != '0);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid && !ex_valid) |-> count < CW'(DEPTH));
  p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken && ex_backward) |=> ent_ok && ent_addr == $past(ex_addr));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && head_pred && !ex_taken) |=> !ent_ok);
  p_fwd_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken && !ex_backward) |=> $stable(ent_ok) && $stable(ent_addr));
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> !mispredict);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> count == '0);
endmodule

// File: tb/sim_loop_predictor.sv
`timescale 1ns/100ps
module sim_loop_predictor;
  localparam int AW = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fq_valid = 1'b0, ex_valid = 1'b0, ex_backward = 1'b0, ex_taken = 1'b0;
  logic [AW-1:0] fq_addr = '0, ex_addr = '0;
  logic fq_taken, mispredict, redirect_taken;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  loop_predictor #(.ADDR_W(AW), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .fq_valid(fq_valid), .fq_addr(fq_addr),
    .fq_taken(fq_taken), .ex_valid(ex_valid), .ex_addr(ex_addr),
    .ex_backward(ex_backward), .ex_taken(ex_taken),
    .mispredict(mispredict), .redirect_taken(redirect_taken));

  // row: {addr, backward, taken, expected prediction, expected mispredict}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {32'h100, 4'b1101},  // R2 first taken backward, learned
    {32'h100, 4'b1110},  // R2 predicted taken
    {32'h200, 4'b0101},  // R6 forward taken
    {32'h100, 4'b1110},  // R6 entry kept
    {32'h300, 4'b1000},  // R3 other address
    {32'h100, 4'b1011},  // R4 falls through
    {32'h100, 4'b1000},  // R4 now not taken
    {32'h100, 4'b1101},  // R2 relearned
    {32'h400, 4'b1101},  // R7 replaces
    {32'h100, 4'b1101},  // R7 old address lost
    {32'h400, 4'b1000},  // R7 replaced in turn
    {32'h100, 4'b1110}   // R7 match keeps entry
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic fv, input logic [AW-1:0] fa,
                       input logic ev, input logic [AW-1:0] ea,
                       input logic eb, input logic et);
    @(negedge clk);
    fq_valid = fv; fq_addr = fa;
    ex_valid = ev; ex_addr = ea; ex_backward = eb; ex_taken = et;
    #1;
  endtask

  task automatic idle();
    drive(0, '0, 0, '0, 0, 0);
  endtask

  task automatic branch(input logic [AW-1:0] a, input logic b, input logic t,
                        input logic ep, input logic em, input string req);
    drive(1, a, 0, '0, 0, 0);
    check({req, " prediction"}, fq_taken, ep);
    drive(0, '0, 1, a, b, t);
    idle();
    check({req, " mispredict"}, mispredict, em);
    check({req, " redirect"}, redirect_taken, em & t);
    idle();
    check("R5 single pulse", mispredict, 1'b0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    drive(1, 32'h100, 0, '0, 0, 0);
    check("R1 reset prediction", fq_taken, 1'b0);
    check("R1 reset mispredict", mispredict, 1'b0);
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < NV; i++)
      branch(VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
             "R2/R3/R4/R6/R7 table");

    // R8: several in flight, alternating predictions resolved in order
    branch(32'h500, 1, 1, 0, 1, "R2 learn 500");
    drive(1, 32'h500, 0, '0, 0, 0); check("R8 fetch a", fq_taken, 1'b1);
    drive(1, 32'h600, 0, '0, 0, 0); check("R8 fetch b", fq_taken, 1'b0);
    drive(1, 32'h500, 0, '0, 0, 0); check("R8 fetch c", fq_taken, 1'b1);
    drive(0, '0, 1, 32'h500, 1, 1);
    drive(0, '0, 1, 32'h600, 0, 0); check("R8 resolve a", mispredict, 1'b0);
    drive(0, '0, 1, 32'h500, 1, 1); check("R8 resolve b", mispredict, 1'b0);
    idle();                         check("R8 resolve c", mispredict, 1'b0);

    // R9/R10: flush of younger predictions and of a same-cycle fetch
    drive(1, 32'h500, 0, '0, 0, 0); check("R8 fetch d", fq_taken, 1'b1);
    drive(1, 32'h500, 0, '0, 0, 0); check("R8 fetch e", fq_taken, 1'b1);
    drive(1, 32'h500, 1, 32'h500, 1, 0);
    check("R10 old entry seen", fq_taken, 1'b1);
    idle();
    check("R4 mispredict on fall-through", mispredict, 1'b1);
    check("R5 redirect fall-through", redirect_taken, 1'b0);
    drive(1, 32'h500, 0, '0, 0, 0); check("R4 cleared", fq_taken, 1'b0);
    drive(0, '0, 1, 32'h500, 1, 0);
    idle(); check("R9 stale predictions flushed", mispredict, 1'b0);

    // R1: reset mid-run clears a learned entry
    branch(32'hC00, 1, 1, 0, 1, "R2 learn C00");
    rst_n = 1'b0;
    idle(); idle();
    rst_n = 1'b1;
    drive(1, 32'hC00, 0, '0, 0, 0); check("R1 entry cleared", fq_taken, 1'b0);
    check("R1 mispredict low", mispredict, 1'b0);
    drive(0, '0, 1, 32'hC00, 1, 0);
    idle(); check("R1 queue empty after reset", mispredict, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule